// File: doc/BRIEF.md
# Byte-Wide Configuration Loader

This block plays the host role when a programmable device is loaded with its configuration image over an 8-bit parallel bus. A local source delivers image bytes through a valid/ready handshake. A load is started with a one-cycle `start` strobe together with the image length. For each attempt the loader pulses an active-low start line to the target and waits for the target's status line to go high. It then places the bytes one at a time on `cfg_data` and raises a divided configuration clock after each byte has settled. When the source has nothing to offer, the clock stays low for as long as needed.

Once the last byte has been clocked, the loader waits for the target's done line and a low-to-high edge on its init-done line. Either one missing within a timeout counts as a failed attempt. So does a status line that drops while bytes are moving, or a status line that never rises. After a failed attempt the loader starts again with a fresh start pulse, and the source replays the image from its first byte. When the retry budget is spent the loader raises a sticky failure flag. A completed load raises a sticky success flag. Outside a load, the clock and data outputs are held at zero.

Top module: `pcfg_host`

## Requirements
- R1: After reset, `cfg_start_n` is 1; `cfg_clk`, `cfg_data`, `s_ready`, `load_busy`, `load_ok` and `load_fail` are all 0.
- R2: A `start` strobe accepted while the loader is not busy drives `cfg_start_n` low for exactly PULSE_CYCLES clock cycles, after which it returns high.
- R3: During the start pulse and until the synchronized status input has been seen high, `s_ready` and `cfg_clk` stay 0. If status is not seen high within STAT_TIMEOUT cycles after the pulse, the attempt fails.
- R4: Each accepted byte (`s_valid` and `s_ready` high at a rising edge) is placed on `cfg_data` while `cfg_clk` is low. `cfg_data` holds still while `cfg_clk` is high. `cfg_clk` rises only after at least CLK_DIV low cycles carrying the byte, and stays high for exactly CLK_DIV cycles. Bytes reach the target in stream order.
- R5: `cfg_clk` never rises without a freshly accepted byte, so while `s_valid` is low the clock pauses low for any length of time.
- R6: Every attempt clocks out exactly `image_len` bytes, even when the done input rises before the final byte.
- R7: When the done input is high and a low-to-high edge has been seen on init-done after the last byte, within INIT_TIMEOUT cycles, `load_ok` is set and `load_busy` falls. `load_ok` stays set until the next `start`.
- R8: A missing done or init-done edge after the full image ends the attempt, and a new start pulse follows.
- R9: Status falling low while bytes are being transferred ends the attempt, and a new start pulse follows.
- R10: After MAX_RETRY+1 failed attempts, `load_fail` is set and stays set until the next `start`. `load_ok` and `load_fail` are never both high.
- R11: Whenever `load_busy` is 0, `cfg_clk` and `cfg_data` are driven 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| image_len | input | LEN_W | Image length in bytes, captured at start |
| s_data | input | 8 | Image byte from the source |
| s_valid | input | 1 | Source byte is valid |
| s_ready | output | 1 | Loader accepts a byte this cycle |
| cfg_start_n | output | 1 | Active-low configuration start to the target |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_data | output | 8 | Configuration data bus to the target |
| tgt_status | input | 1 | Target status, high when ready for data |
| tgt_done | input | 1 | Target configuration-done |
| tgt_init_done | input | 1 | Target initialization-done |
| load_busy | output | 1 | A load attempt is in progress |
| load_ok | output | 1 | Sticky success flag |
| load_fail | output | 1 | Sticky failure flag |

## Verification
Two things can land on the same byte: the target's done line rising early, and the clocking of the final byte. The bench's target model asserts done as soon as all but one byte have arrived, for every image length from one to six and for several source gap patterns. It then judges the attempt by the number of clock rises and the byte values the model captured, which must equal the full length and the stream. A second overlap comes from the status drop: the model pulls status low mid-image, and the bench judges that the loader abandons the byte stream and issues exactly one extra start pulse.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PULSE  = 3'd1,
        ST_WSTAT  = 3'd2,
        ST_LOW    = 3'd3,
        ST_HIGH   = 3'd4,
        ST_WINIT  = 3'd5,
        ST_OK     = 3'd6,
        ST_FAIL   = 3'd7
    } pcfg_state_e;

endpackage

// File: rtl/pcfg_sync.sv
// Multi-stage synchronizer for the target's asynchronous status lines.
module pcfg_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] stage_d, stage_q;

            always_comb begin
                stage_d[0] = d;
                for (int i = 1; i < STAGES; i++) begin
                    stage_d[i] = stage_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= stage_d;
            end

            assign q = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pcfg_count.sv
// Up-counter with clear priority; hit flags when the count has reached the limit.
module pcfg_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                     cnt_d = '0;
        else if (en && !(cnt_q >= limit)) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = (cnt_q >= limit);
endmodule

// File: rtl/pcfg_host.sv
module pcfg_host
    import pcfg_pkg::*;
#(
    parameter int CLK_DIV      = 4,
    parameter int PULSE_CYCLES = 8,
    parameter int STAT_TIMEOUT = 1000,
    parameter int INIT_TIMEOUT = 1000,
    parameter int MAX_RETRY    = 3,
    parameter int LEN_W        = 24,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] image_len,
    input  logic [7:0]       s_data,
    input  logic             s_valid,
    output logic             s_ready,
    output logic             cfg_start_n,
    output logic             cfg_clk,
    output logic [7:0]       cfg_data,
    input  logic             tgt_status,
    input  logic             tgt_done,
    input  logic             tgt_init_done,
    output logic             load_busy,
    output logic             load_ok,
    output logic             load_fail
);
    localparam int PH_W   = $clog2(CLK_DIV + 1);
    localparam int TM_MAX = (PULSE_CYCLES > STAT_TIMEOUT)
                          ? ((PULSE_CYCLES > INIT_TIMEOUT) ? PULSE_CYCLES : INIT_TIMEOUT)
                          : ((STAT_TIMEOUT > INIT_TIMEOUT) ? STAT_TIMEOUT : INIT_TIMEOUT);
    localparam int TM_W   = $clog2(TM_MAX + 1);
    localparam int RT_W   = $clog2(MAX_RETRY + 2);

    typedef struct packed {
        pcfg_state_e      st;
        logic             pulse;      // start line asserted (output is inverted)
        logic             cclk;
        logic [7:0]       data;
        logic             have;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] sent;
        logic [RT_W-1:0]  tries;
        logic             ok;
        logic             fail;
        logic             init_prev;
        logic             init_seen;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0] sync_q;
    logic       stat_s, done_s, init_s;
    logic       tm_clr, tm_en, tm_hit;
    logic       ph_clr, ph_en, ph_hit;
    logic [TM_W-1:0] tm_limit;
    logic       do_fail;
    logic [LEN_W-1:0] sent_nx;

    pcfg_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({tgt_status, tgt_done, tgt_init_done}),
        .q     (sync_q)
    );
    assign {stat_s, done_s, init_s} = sync_q;

    pcfg_count #(.W(TM_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tm_clr),
        .en    (tm_en),
        .limit (tm_limit),
        .hit   (tm_hit)
    );

    pcfg_count #(.W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ph_clr),
        .en    (ph_en),
        .limit (PH_W'(CLK_DIV - 1)),
        .hit   (ph_hit)
    );

    always_comb begin
        case (r_q.st)
            ST_PULSE: tm_limit = TM_W'(PULSE_CYCLES - 1);
            ST_WSTAT: tm_limit = TM_W'(STAT_TIMEOUT - 1);
            default:  tm_limit = TM_W'(INIT_TIMEOUT - 1);
        endcase
    end

    assign sent_nx = r_q.sent + LEN_W'(1);
    assign s_ready = (r_q.st == ST_LOW) && !r_q.have && stat_s;

    always_comb begin
        r_d     = r_q;
        tm_clr  = 1'b0;
        tm_en   = 1'b0;
        ph_clr  = 1'b0;
        ph_en   = 1'b0;
        do_fail = 1'b0;

        r_d.init_prev = init_s;
        if (init_s && !r_q.init_prev) r_d.init_seen = 1'b1;

        case (r_q.st)
            ST_IDLE, ST_OK, ST_FAIL: begin
                r_d.cclk = 1'b0;
                r_d.data = '0;
                if (start) begin
                    r_d.st        = ST_PULSE;
                    r_d.pulse     = 1'b1;
                    r_d.tries     = '0;
                    r_d.ok        = 1'b0;
                    r_d.fail      = 1'b0;
                    r_d.init_seen = 1'b0;
                    r_d.len       = image_len;
                    tm_clr        = 1'b1;
                end
            end
            ST_PULSE: begin
                tm_en         = 1'b1;
                r_d.init_seen = 1'b0;
                if (tm_hit) begin
                    r_d.st    = ST_WSTAT;
                    r_d.pulse = 1'b0;
                    tm_clr    = 1'b1;
                end
            end
            ST_WSTAT: begin
                tm_en = 1'b1;
                if (stat_s) begin
                    r_d.sent = '0;
                    r_d.have = 1'b0;
                    tm_clr   = 1'b1;
                    ph_clr   = 1'b1;
                    r_d.st   = (r_q.len == '0) ? ST_WINIT : ST_LOW;
                end else if (tm_hit) begin
                    do_fail = 1'b1;
                end
            end
            ST_LOW: begin
                if (!stat_s) begin
                    do_fail = 1'b1;
                end else if (!r_q.have) begin
                    if (s_valid) begin
                        r_d.data = s_data;
                        r_d.have = 1'b1;
                        ph_clr   = 1'b1;
                    end
                end else begin
                    ph_en = 1'b1;
                    if (ph_hit) begin
                        r_d.st   = ST_HIGH;
                        r_d.cclk = 1'b1;
                        ph_clr   = 1'b1;
                    end
                end
            end
            ST_HIGH: begin
                if (!stat_s) begin
                    do_fail = 1'b1;
                end else begin
                    ph_en = 1'b1;
                    if (ph_hit) begin
                        r_d.cclk = 1'b0;
                        r_d.have = 1'b0;
                        r_d.sent = sent_nx;
                        ph_clr   = 1'b1;
                        if (sent_nx == r_q.len) begin
                            r_d.st = ST_WINIT;
                            tm_clr = 1'b1;
                        end else begin
                            r_d.st = ST_LOW;
                        end
                    end
                end
            end
            ST_WINIT: begin
                tm_en = 1'b1;
                if (r_q.init_seen && done_s) begin
                    r_d.st   = ST_OK;
                    r_d.ok   = 1'b1;
                    r_d.data = '0;
                end else if (tm_hit) begin
                    do_fail = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (do_fail) begin
            r_d.cclk = 1'b0;
            r_d.data = '0;
            r_d.have = 1'b0;
            tm_clr   = 1'b1;
            if (r_q.tries == RT_W'(MAX_RETRY)) begin
                r_d.st   = ST_FAIL;
                r_d.fail = 1'b1;
            end else begin
                r_d.tries     = r_q.tries + RT_W'(1);
                r_d.st        = ST_PULSE;
                r_d.pulse     = 1'b1;
                r_d.init_seen = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_start_n = !r_q.pulse;
    assign cfg_clk     = r_q.cclk;
    assign cfg_data    = r_q.data;
    assign load_ok     = r_q.ok;
    assign load_fail   = r_q.fail;
    assign load_busy   = !(r_q.st == ST_IDLE || r_q.st == ST_OK || r_q.st == ST_FAIL);
endmodule

// File: rtl/pcfg_host_chk.sv
module pcfg_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       s_ready,
    input logic       cfg_start_n,
    input logic       cfg_clk,
    input logic [7:0] cfg_data,
    input logic       load_busy,
    input logic       load_ok,
    input logic       load_fail
);
    p_idle_lines_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_busy |-> (!cfg_clk && cfg_data == 8'h00));

    p_hold_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk |-> $stable(cfg_data));

    p_ready_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !cfg_clk);

    p_quiet_in_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_start_n |-> (!s_ready && !cfg_clk));

    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_ok && load_fail));

    p_ok_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok && !start) |=> load_ok);

    p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fail && !start) |=> load_fail);

    p_busy_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_busy |-> (!load_ok && !load_fail));
endmodule

bind pcfg_host pcfg_host_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .s_ready     (s_ready),
    .cfg_start_n (cfg_start_n),
    .cfg_clk     (cfg_clk),
    .cfg_data    (cfg_data),
    .load_busy   (load_busy),
    .load_ok     (load_ok),
    .load_fail   (load_fail)
);

// File: tb/pcfg_host_bench.sv
`timescale 1ns/1ps
module pcfg_host_bench;
    localparam int DIV   = 2;
    localparam int PULSE = 3;
    localparam int STO   = 16;
    localparam int ITO   = 24;
    localparam int RETRY = 2;
    localparam int LW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LW-1:0] image_len = '0;
    logic [7:0] s_data = '0;
    logic s_valid = 1'b0;
    logic s_ready, cfg_start_n, cfg_clk, load_busy, load_ok, load_fail;
    logic [7:0] cfg_data;
    logic tstat = 1'b0, tdone = 1'b0, tinit = 1'b0;

    always #2.5 clk = ~clk;

    pcfg_host #(
        .CLK_DIV(DIV), .PULSE_CYCLES(PULSE), .STAT_TIMEOUT(STO),
        .INIT_TIMEOUT(ITO), .MAX_RETRY(RETRY), .LEN_W(LW), .SYNC_STAGES(2)
    ) u_pcfg_host (
        .clk(clk), .rst_n(rst_n), .start(start), .image_len(image_len),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .cfg_start_n(cfg_start_n), .cfg_clk(cfg_clk), .cfg_data(cfg_data),
        .tgt_status(tstat), .tgt_done(tdone), .tgt_init_done(tinit),
        .load_busy(load_busy), .load_ok(load_ok), .load_fail(load_fail)
    );

    int tests = 0, fails = 0;
    int seed = 0;
    int cfg_len = 1, cfg_gap = 0, cfg_kind = 0, cfg_fail_n = 0;
    // model / monitor state
    int attempt = 0, pulse_run = 0, pulse_bad = 0;
    int stat_cnt = 0, init_cnt = 0, tcount = 0, rises = 0;
    bit stat_seen = 0, dropped = 0, prev_sn = 1, prev_clk = 0, fresh = 0, hs_prev = 0;
    int hi_run = 0, lo_run = 0, hw_viol = 0, lo_viol = 0, pre_viol = 0, starve = 0, byte_err = 0;
    int src_idx = 0, gapc = 0;
    int cyc = 0;
    bit wd_hit = 0;

    function automatic logic [7:0] img(input int i);
        return 8'(((i * 37) + (seed * 11)) ^ 8'h5A);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit faulty;
        if (hs_prev) begin
            src_idx++;
            s_valid = 1'b0;
            gapc    = cfg_gap;
            fresh   = 1'b1;
        end
        faulty = (attempt >= 1) && (attempt <= cfg_fail_n);
        if (!cfg_start_n) begin
            if (prev_sn) begin attempt++; pulse_run = 0; end
            pulse_run++;
            tstat = 0; tdone = 0; tinit = 0; tcount = 0; stat_cnt = 0; init_cnt = 0;
            dropped = 0; stat_seen = 0; src_idx = 0; s_valid = 0; gapc = 0;
            fresh = 0; rises = 0; hs_prev = 0;
        end else begin
            if (!prev_sn && attempt > 0 && pulse_run != PULSE) pulse_bad++;
            if (attempt > 0 && !dropped && !(faulty && cfg_kind == 1)) begin
                if (stat_cnt < 3) stat_cnt++;
                else begin tstat = 1; stat_seen = 1; end
            end
            // clock edge detection
            if (cfg_clk && !prev_clk) begin
                if (!stat_seen) pre_viol++;
                if (!fresh) starve++;
                fresh = 0;
                if (lo_run < DIV) lo_viol++;
                if (cfg_data != img(tcount)) byte_err++;
                tcount++;
                rises++;
                hi_run = 1;
            end else if (cfg_clk) begin
                hi_run++;
            end else if (prev_clk) begin
                if (hi_run != DIV && cfg_kind != 4) hw_viol++;
                lo_run = 1;
            end else begin
                lo_run++;
            end
            if (s_ready && !stat_seen) pre_viol++;
            if (faulty && cfg_kind == 4 && tcount == 2 && tstat) begin
                tstat = 0; dropped = 1;
            end
            tdone = stat_seen && !(faulty && cfg_kind == 2) && (tcount + 1 >= cfg_len);
            if (tdone && tcount == cfg_len && !(faulty && cfg_kind == 3)) begin
                init_cnt++;
                if (init_cnt >= 6) tinit = 1;
            end
            if (!s_valid && attempt > 0 && src_idx < cfg_len) begin
                if (gapc > 0) gapc--;
                else begin s_valid = 1; s_data = img(src_idx); end
            end
            hs_prev = s_valid && s_ready;
        end
        prev_sn  = cfg_start_n;
        prev_clk = cfg_clk;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !wd_hit) begin
            wd_hit = 1;
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic run_case(input int len, input int gap, input int kind, input int fail_n,
                            input bit exp_ok, input int exp_att);
        int waitc;
        @(negedge clk);
        seed = seed + 1;
        cfg_len = len; cfg_gap = gap; cfg_kind = kind; cfg_fail_n = fail_n;
        attempt = 0; pulse_bad = 0; hw_viol = 0; lo_viol = 0; pre_viol = 0;
        starve = 0; byte_err = 0; lo_run = 0;
        image_len = LW'(len);
        start = 1;
        @(negedge clk);
        start = 0;
        waitc = 0;
        while (load_busy && waitc < 20000) begin
            @(negedge clk);
            waitc++;
        end
        chk(!load_busy, "R7 busy end", int'(load_busy), 0);
        chk(load_ok == exp_ok, "R7 ok flag", int'(load_ok), int'(exp_ok));
        chk(load_fail == !exp_ok, "R10 fail flag", int'(load_fail), int'(!exp_ok));
        chk(attempt == exp_att, "R8 R9 R10 attempts", attempt, exp_att);
        chk(pulse_bad == 0, "R2 pulse width", pulse_bad, 0);
        chk(pre_viol == 0, "R3 quiet before status", pre_viol, 0);
        chk(byte_err == 0, "R4 byte order", byte_err, 0);
        chk(hw_viol == 0 && lo_viol == 0, "R4 clock phases", hw_viol + lo_viol, 0);
        chk(starve == 0, "R5 no rise without byte", starve, 0);
        if (exp_ok) chk(rises == len, "R6 full image clocked", rises, len);
        chk(cfg_clk == 0 && cfg_data == 0, "R11 lines parked", int'(cfg_data) + int'(cfg_clk), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cfg_start_n == 1, "R1 start line", int'(cfg_start_n), 1);
        chk(cfg_clk == 0 && cfg_data == 0, "R1 clk data", int'(cfg_clk) + int'(cfg_data), 0);
        chk(s_ready == 0 && load_busy == 0, "R1 ready busy", int'(s_ready) + int'(load_busy), 0);
        chk(load_ok == 0 && load_fail == 0, "R1 flags", int'(load_ok) + int'(load_fail), 0);

        // R6 / R4 sweep: every short length against several source gap patterns
        for (int len = 1; len <= 6; len++) begin
            for (int gap = 0; gap <= 3; gap++) begin
                run_case(len, gap, 0, 0, 1'b1, 1);
            end
        end
        // R5: long source stalls
        run_case(4, 40, 0, 0, 1'b1, 1);
        // R3: status late once, then ok
        run_case(3, 0, 1, 1, 1'b1, 2);
        // R8: missing done once, missing init-done twice
        run_case(5, 1, 2, 1, 1'b1, 2);
        run_case(4, 0, 3, 2, 1'b1, 3);
        // R9: status drop mid-image
        run_case(5, 0, 4, 1, 1'b1, 2);
        run_case(6, 2, 4, 2, 1'b1, 3);
        // R10: every attempt fails
        run_case(3, 0, 1, 99, 1'b0, RETRY + 1);
        run_case(4, 0, 2, 99, 1'b0, RETRY + 1);
        run_case(5, 0, 4, 99, 1'b0, RETRY + 1);
        // restart after failure clears the failure flag
        run_case(2, 0, 0, 0, 1'b1, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule